// File: doc/BRIEF.md
# Multi-Channel Step and Direction Pulse Generator

This block turns a signed rate word per channel into a step pulse train and a direction level for stepper motor drivers. Each channel runs a phase accumulator fed with the magnitude of its rate word. An overflow raises a pending step, and the step is issued as soon as the pulse timing allows it. The direction output follows the sign of the rate word. It changes only when the channel is quiet, and a settling time is enforced on both sides of the change.

Three timing settings are shared by every channel: pulse high time, minimum low time, and a single direction settling time. The settling time serves both as hold after the last step and as setup before the next one. Each setting is a count of 64-clock units. At 40 MHz one unit is 1.6 µs and the largest setting, 31 units, is 49.6 µs. A high and low time of one unit each gives the fastest train, one step per 128 clocks (312.5 kHz at 40 MHz).

Every channel also keeps a signed count of the steps it has issued. A per-channel strobe copies that count to the position output, where the host reads it.

Top module: `stepdir_pulse_gen`

## Requirements
- R1: When the channel is not limited by its pulse timing, it issues rising step edges at an average of |rate| / 2^ACC_W per clock. The rate word for channel c is the two's complement field rate_i[c*RATE_W +: RATE_W].
- R2: dir_o[c] is 1 while the rate word is negative and 0 while it is positive. A zero rate word leaves dir_o unchanged and starts no new steps.
- R3: A step pulse stays high for exactly max(mark,1)*64 clocks, where mark is the value of mark_units_i.
- R4: Between two pulses, step_o stays low for at least max(space,1)*64 clocks. A pending step is never dropped. When steps are backlogged, the next rise comes exactly after that low time, so a mark and space of 1 each give one step every 128 clocks.
- R5: After dir_o changes, the next rising step edge comes no earlier than dir*64 clocks later, where dir is the value of dir_units_i.
- R6: dir_o never changes while step_o is high. It changes only once the low time has elapsed and at least dir*64 clocks after the last falling step edge.
- R7: The internal position count starts at 0. Each issued step adds 1 when dir_o is 0 and subtracts 1 when dir_o is 1, in POS_W-bit two's complement.
- R8: pos_o[c*POS_W +: POS_W] takes the position count one clock after latch_i[c] is sampled high, and holds its value otherwise.
- R9: During and right after reset, every step_o and dir_o is 0 and every pos_o field is 0.
- R10: All channels apply the same three timing settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 40 MHz in the target system |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_i | input | NUM_CH*RATE_W | Signed rate word per channel |
| mark_units_i | input | TIME_W | Step high time in 64-clock units |
| space_units_i | input | TIME_W | Minimum step low time in 64-clock units |
| dir_units_i | input | TIME_W | Direction setup and hold time in 64-clock units |
| latch_i | input | NUM_CH | Per-channel position capture strobe |
| step_o | output | NUM_CH | Step pulse per channel |
| dir_o | output | NUM_CH | Direction per channel, 1 = negative |
| pos_o | output | NUM_CH*POS_W | Captured signed position per channel |

## Verification
Several rules are checked by the assertions on every clock. A step is taken only while one is pending, and a pending step stays pending until it is taken. No rising step edge comes while the setup window is still open, and the direction never moves while a pulse is high or before the hold window closes. Each issued step moves the position by exactly one, and the captured position is stable without a strobe. Only the bench scenarios can show the exact pulse widths, the minimum and backlogged low times, the average step rate against the rate word, and that the captured position matches the steps seen at the pins in both directions.

// File: rtl/stepdir_pkg.sv
package stepdir_pkg;

   // Pulse phase of one channel
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_MARK  = 2'd1,
      PH_SPACE = 2'd2
   } pulse_phase_e;

   // Number of bits needed for a count of n
   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/stepdir_timing_scale.sv
// Converts the shared unit counts into clock-count load values, registered once
// for all channels.
module stepdir_timing_scale #(
   parameter int TIME_W    = 5,
   parameter int UNIT_CLKS = 64,
   parameter int CNT_W     = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] mark_units_i,
   input  logic [TIME_W-1:0] space_units_i,
   input  logic [TIME_W-1:0] dir_units_i,
   output logic [CNT_W-1:0]  mark_load_o,
   output logic [CNT_W-1:0]  space_load_o,
   output logic [CNT_W-1:0]  dir_load_o
);

   logic [TIME_W-1:0] mark_eff;
   logic [TIME_W-1:0] space_eff;

   // A zero length or space is raised to one unit so a pulse is never empty
   always_comb begin
      mark_eff  = (mark_units_i  == '0) ? TIME_W'(1) : mark_units_i;
      space_eff = (space_units_i == '0) ? TIME_W'(1) : space_units_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_load_o  <= '0;
         space_load_o <= '0;
         dir_load_o   <= '0;
      end else begin
         mark_load_o  <= CNT_W'(mark_eff)  * CNT_W'(UNIT_CLKS) - CNT_W'(1);
         space_load_o <= CNT_W'(space_eff) * CNT_W'(UNIT_CLKS) - CNT_W'(1);
         dir_load_o   <= CNT_W'(dir_units_i) * CNT_W'(UNIT_CLKS);
      end
   end

endmodule

// File: rtl/stepdir_rate_accum.sv
// Phase accumulator of one channel. It raises a pending step on overflow and
// stalls while the step is pending.
module stepdir_rate_accum #(
   parameter int RATE_W = 16,
   parameter int ACC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              take_i,
   output logic              pending_o,
   output logic              want_neg_o,
   output logic              rate_zero_o
);

   localparam int PAD_W = ACC_W + 1 - RATE_W;

   logic signed [RATE_W-1:0] rate_s;
   logic [RATE_W-1:0]        mag;
   logic [ACC_W:0]           sum;
   logic [ACC_W-1:0]         acc_q;
   logic                     pend_q;

   always_comb begin
      rate_s      = $signed(rate_i);
      mag         = rate_s[RATE_W-1] ? RATE_W'(-rate_s) : RATE_W'(rate_s);
      sum         = {1'b0, acc_q} + {{PAD_W{1'b0}}, mag};
      want_neg_o  = rate_s[RATE_W-1];
      rate_zero_o = (rate_i == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         pend_q <= 1'b0;
      end else if (!pend_q) begin
         acc_q <= sum[ACC_W-1:0];
         if (sum[ACC_W]) pend_q <= 1'b1;
      end else if (take_i) begin
         pend_q <= 1'b0;
      end
   end

   assign pending_o = pend_q;

   AST_TAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> pend_q) else $error("take without pending step"); // R1

   AST_PENDING_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !take_i) |=> pend_q) else $error("pending step dropped"); // R4

endmodule

// File: rtl/stepdir_pulse_fsm.sv
// Pulse and direction sequencing of one channel: mark, space, hold and setup.
module stepdir_pulse_fsm
   import stepdir_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pending_i,
   input  logic             want_neg_i,
   input  logic             rate_zero_i,
   input  logic [CNT_W-1:0] mark_load_i,
   input  logic [CNT_W-1:0] space_load_i,
   input  logic [CNT_W-1:0] dir_load_i,
   output logic             take_o,
   output logic             step_o,
   output logic             dir_o
);

   pulse_phase_e     phase_q;
   logic [CNT_W-1:0] tmr_q;
   logic [CNT_W-1:0] hold_q;
   logic [CNT_W-1:0] setup_q;
   logic             step_q;
   logic             dir_q;

   logic ready;
   logic turn;
   logic fire;
   logic mark_end;

   always_comb begin
      ready    = (phase_q == PH_IDLE) || ((phase_q == PH_SPACE) && (tmr_q == '0));
      mark_end = (phase_q == PH_MARK) && (tmr_q == '0);
      turn     = ready && !rate_zero_i && (want_neg_i != dir_q) && (hold_q == '0);
      fire     = ready && !turn && pending_i && (setup_q == '0)
                 && (rate_zero_i || (want_neg_i == dir_q));
   end

   // Hold window after the falling step edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (mark_end) begin
         hold_q <= dir_load_i;
      end else if (hold_q != '0) begin
         hold_q <= hold_q - CNT_W'(1);
      end
   end

   // Setup window after a direction change
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_q <= '0;
      end else if (turn) begin
         setup_q <= dir_load_i;
      end else if (setup_q != '0) begin
         setup_q <= setup_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         tmr_q   <= '0;
         step_q  <= 1'b0;
         dir_q   <= 1'b0;
      end else begin
         case (phase_q)
            PH_MARK: begin
               if (tmr_q == '0) begin
                  phase_q <= PH_SPACE;
                  tmr_q   <= space_load_i;
                  step_q  <= 1'b0;
               end else begin
                  tmr_q <= tmr_q - CNT_W'(1);
               end
            end
            default: begin
               if (turn) begin
                  dir_q   <= ~dir_q;
                  phase_q <= PH_IDLE;
               end else if (fire) begin
                  phase_q <= PH_MARK;
                  tmr_q   <= mark_load_i;
                  step_q  <= 1'b1;
               end else if (phase_q == PH_SPACE) begin
                  if (tmr_q == '0) phase_q <= PH_IDLE;
                  else             tmr_q   <= tmr_q - CNT_W'(1);
               end
            end
         endcase
      end
   end

   assign take_o = fire;
   assign step_o = step_q;
   assign dir_o  = dir_q;

   AST_SETUP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_q) |-> ($past(setup_q) == '0)) else $error("step inside setup window"); // R5

   AST_DIR_STILL_IN_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      step_q |-> $stable(dir_q)) else $error("direction moved during pulse"); // R6

   AST_DIR_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q != $past(dir_q)) |-> (!$past(step_q) && ($past(hold_q) == '0)))
      else $error("direction moved inside hold window"); // R6

endmodule

// File: rtl/stepdir_pos_track.sv
// Signed feedback position of one channel and its host-side capture.
module stepdir_pos_track #(
   parameter int POS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             dir_neg_i,
   input  logic             latch_i,
   output logic [POS_W-1:0] pos_o
);

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (step_i) begin
         pos_q <= dir_neg_i ? (pos_q - POS_W'(1)) : (pos_q + POS_W'(1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (latch_i) begin
         cap_q <= pos_q;
      end
   end

   assign pos_o = cap_q;

   AST_POS_UNIT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> ((pos_q == $past(pos_q) + POS_W'(1)) || (pos_q == $past(pos_q) - POS_W'(1))))
      else $error("position did not move by one"); // R7

   AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_i |=> $stable(cap_q)) else $error("capture changed without strobe"); // R8

endmodule

// File: rtl/stepdir_pulse_gen.sv
// Multi-channel step and direction generator with shared pulse timing.
module stepdir_pulse_gen #(
   parameter int NUM_CH    = 4,
   parameter int RATE_W    = 16,
   parameter int ACC_W     = 16,
   parameter int TIME_W    = 5,
   parameter int UNIT_CLKS = 64,
   parameter int POS_W     = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*RATE_W-1:0] rate_i,
   input  logic [TIME_W-1:0]        mark_units_i,
   input  logic [TIME_W-1:0]        space_units_i,
   input  logic [TIME_W-1:0]        dir_units_i,
   input  logic [NUM_CH-1:0]        latch_i,
   output logic [NUM_CH-1:0]        step_o,
   output logic [NUM_CH-1:0]        dir_o,
   output logic [NUM_CH*POS_W-1:0]  pos_o
);

   localparam int MAX_CLKS = ((1 << TIME_W) - 1) * UNIT_CLKS;
   localparam int CNT_W    = stepdir_pkg::cnt_bits(MAX_CLKS);

   // Elaboration-time parameter checks
   if (NUM_CH < 1)        begin : g_bad_ch   $error("NUM_CH must be at least 1");   end
   if (RATE_W < 2)        begin : g_bad_rate $error("RATE_W must be at least 2");   end
   if (ACC_W < RATE_W)    begin : g_bad_acc  $error("ACC_W must cover RATE_W");     end
   if (TIME_W < 1)        begin : g_bad_time $error("TIME_W must be at least 1");   end
   if (UNIT_CLKS < 1)     begin : g_bad_unit $error("UNIT_CLKS must be positive");  end
   if (POS_W < 2)         begin : g_bad_pos  $error("POS_W must be at least 2");    end

   logic [CNT_W-1:0] mark_load;
   logic [CNT_W-1:0] space_load;
   logic [CNT_W-1:0] dir_load;

   // One shared timing scaler feeds every channel (R10)
   stepdir_timing_scale #(
      .TIME_W    (TIME_W),
      .UNIT_CLKS (UNIT_CLKS),
      .CNT_W     (CNT_W)
   ) timing_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .mark_units_i  (mark_units_i),
      .space_units_i (space_units_i),
      .dir_units_i   (dir_units_i),
      .mark_load_o   (mark_load),
      .space_load_o  (space_load),
      .dir_load_o    (dir_load)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic pending;
      logic want_neg;
      logic rate_zero;
      logic take;

      stepdir_rate_accum #(
         .RATE_W (RATE_W),
         .ACC_W  (ACC_W)
      ) accum_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .rate_i      (rate_i[c*RATE_W +: RATE_W]),
         .take_i      (take),
         .pending_o   (pending),
         .want_neg_o  (want_neg),
         .rate_zero_o (rate_zero)
      );

      stepdir_pulse_fsm #(
         .CNT_W (CNT_W)
      ) fsm_i (
         .clk          (clk),
         .rst_n        (rst_n),
         .pending_i    (pending),
         .want_neg_i   (want_neg),
         .rate_zero_i  (rate_zero),
         .mark_load_i  (mark_load),
         .space_load_i (space_load),
         .dir_load_i   (dir_load),
         .take_o       (take),
         .step_o       (step_o[c]),
         .dir_o        (dir_o[c])
      );

      stepdir_pos_track #(
         .POS_W (POS_W)
      ) pos_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .step_i    (take),
         .dir_neg_i (dir_o[c]),
         .latch_i   (latch_i[c]),
         .pos_o     (pos_o[c*POS_W +: POS_W])
      );
   end

   AST_ZERO_RATE_NO_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_i[RATE_W-1:0] == '0) |=> $stable(dir_o[0])) else $error("direction moved at zero rate"); // R2

endmodule

// File: tb/stepdir_pulse_gen_tb.sv
module stepdir_pulse_gen_tb_top;

   localparam int NCH  = 4;
   localparam int RW   = 16;
   localparam int PW   = 32;
   localparam int UNIT = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH*RW-1:0] rate = '0;
   logic [4:0]        mark_u = 5'd1;
   logic [4:0]        space_u = 5'd1;
   logic [4:0]        dir_u = 5'd0;
   logic [NCH-1:0]    latch = '0;
   logic [NCH-1:0]    step;
   logic [NCH-1:0]    dir;
   logic [NCH*PW-1:0] pos;

   always #4 clk = ~clk;

   stepdir_pulse_gen #(
      .NUM_CH (NCH), .RATE_W (RW), .ACC_W (16), .TIME_W (5), .UNIT_CLKS (UNIT), .POS_W (PW)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .rate_i (rate),
      .mark_units_i (mark_u), .space_units_i (space_u), .dir_units_i (dir_u),
      .latch_i (latch), .step_o (step), .dir_o (dir), .pos_o (pos)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Scoreboard: expected pulse rules pushed by the driver, consumed by the monitor
   typedef struct {
      int width;
      int gap;
      int dtime;
   } rule_t;

   rule_t exp_q[$];
   rule_t cur = '{width: 64, gap: 64, dtime: 0};

   int   hi_c[NCH];
   int   lo_c[NCH];
   int   since_dir[NCH];
   int   rises[NCH];
   int   mpos[NCH];
   logic prev_step[NCH];
   logic prev_dir[NCH];

   initial begin
      for (int c = 0; c < NCH; c++) begin
         hi_c[c] = 0; lo_c[c] = 100000; since_dir[c] = 100000;
         rises[c] = 0; mpos[c] = 0; prev_step[c] = 1'b0; prev_dir[c] = 1'b0;
      end
   end

   // Monitor: samples at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (exp_q.size() > 0 && step == '0) cur = exp_q.pop_front();
         for (int c = 0; c < NCH; c++) begin
            if (since_dir[c] < 100000) since_dir[c]++;
            if (dir[c] != prev_dir[c]) begin
               check(step[c] == 1'b0, "R6 dir change while step high", int'(step[c]), 0);
               check(lo_c[c] - 1 >= cur.dtime, "R6 dir hold after fall", lo_c[c] - 1, cur.dtime);
               check(lo_c[c] >= cur.gap, "R6 dir change before space end", lo_c[c], cur.gap);
               since_dir[c] = 0;
            end
            if (step[c]) begin
               if (!prev_step[c]) begin
                  check(lo_c[c] >= cur.gap, "R4 low time", lo_c[c], cur.gap);
                  check(since_dir[c] >= cur.dtime, "R5 dir setup", since_dir[c], cur.dtime);
                  rises[c]++;
                  mpos[c] += dir[c] ? -1 : 1;
                  hi_c[c] = 1;
               end else begin
                  hi_c[c]++;
               end
            end else begin
               if (prev_step[c]) begin
                  check(hi_c[c] == cur.width, "R3 step width", hi_c[c], cur.width);
                  lo_c[c] = 1;
               end else if (lo_c[c] < 100000) begin
                  lo_c[c]++;
               end
            end
            prev_step[c] = step[c];
            prev_dir[c]  = dir[c];
         end
      end
   end

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_rate(input int c, input int val);
      @(negedge clk);
      rate[c*RW +: RW] = RW'(val);
   endtask

   task automatic quiesce(input int n);
      @(negedge clk);
      rate = '0;
      wait_clks(n);
   endtask

   task automatic set_timing(input int m, input int s, input int d);
      rule_t r;
      @(negedge clk);
      mark_u  = 5'(m);
      space_u = 5'(s);
      dir_u   = 5'(d);
      r.width = ((m == 0) ? 1 : m) * UNIT;
      r.gap   = ((s == 0) ? 1 : s) * UNIT;
      r.dtime = d * UNIT;
      exp_q.push_back(r);
      wait_clks(4);
   endtask

   task automatic latch_check(input int c, input string req);
      @(negedge clk);
      latch[c] = 1'b1;
      @(negedge clk);
      latch[c] = 1'b0;
      @(negedge clk);
      check($signed(pos[c*PW +: PW]) == mpos[c], req, $signed(pos[c*PW +: PW]), mpos[c]);
   endtask

   // Rising step edges on channel c over n clocks, compared with the expected band
   task automatic rate_window(input int c, input int n, input int lo, input int hi, input string req);
      int r0;
      @(posedge clk);
      r0 = rises[c];
      wait_clks(n);
      @(posedge clk);
      check((rises[c] - r0 >= lo) && (rises[c] - r0 <= hi), req, rises[c] - r0, lo);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : driver
      int p0;
      wait_clks(5);
      // R9: reset state
      check(step == '0, "R9 step in reset", int'(step), 0);
      check(dir == '0, "R9 dir in reset", int'(dir), 0);
      check(pos == '0, "R9 pos in reset", int'(pos[31:0]), 0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_clks(3);
      check(step == '0 && dir == '0 && pos == '0, "R9 after release", int'(step), 0);

      // Rates below the limit, both signs
      set_timing(1, 2, 3);
      set_rate(0, 256);
      set_rate(1, -300);
      rate_window(0, 5120, 19, 21, "R1 rate +256 count");
      check(dir[0] == 1'b0, "R2 dir positive", int'(dir[0]), 0);
      check(dir[1] == 1'b1, "R2 dir negative", int'(dir[1]), 1);
      check(rises[2] == 0 && dir[2] == 1'b0, "R2 zero rate idle", rises[2], 0);
      check(pos == '0, "R8 pos held without strobe", int'(pos[31:0]), 0);
      rate_window(1, 5120, 22, 24, "R1 rate -300 count");

      quiesce(3000);
      check(dir[1] == 1'b1, "R2 dir held at zero rate", int'(dir[1]), 1);
      latch_check(0, "R7 R8 pos ch0 positive");
      latch_check(1, "R7 R8 pos ch1 negative");
      check(mpos[1] < 0, "R7 negative steps count down", mpos[1], -1);

      // Reverse both channels: hold and setup checked by the monitor
      set_rate(0, -256);
      set_rate(1, 300);
      wait_clks(4000);
      check(dir[0] == 1'b1 && dir[1] == 1'b0, "R2 reversal", int'(dir[1:0]), 1);
      quiesce(3000);
      latch_check(0, "R7 pos ch0 after reversal");
      latch_check(1, "R7 pos ch1 after reversal");

      // Backlogged channels at the fastest timing: one step per 128 clocks
      set_timing(1, 1, 0);
      set_rate(2, 4000);
      set_rate(3, -4000);
      wait_clks(500);
      rate_window(2, 128 * 40, 39, 41, "R4 backlog rate ch2");
      rate_window(3, 128 * 40, 39, 41, "R10 backlog rate ch3");
      quiesce(1000);
      latch_check(2, "R7 pos ch2 backlog");
      latch_check(3, "R7 pos ch3 backlog");

      // Zero unit counts act as one unit
      set_timing(0, 0, 0);
      set_rate(0, 1000);
      rate_window(0, 128 * 15, 14, 16, "R3 R4 zero units as one");
      quiesce(1000);

      // Largest settings: 1984-clock pulse, space and settling
      set_timing(31, 31, 31);
      set_rate(0, 20);
      p0 = rises[0];
      wait_clks(12000);
      check(rises[0] - p0 >= 2, "R3 long pulses seen", rises[0] - p0, 2);
      set_rate(0, -20);
      wait_clks(12000);
      check(dir[0] == 1'b1, "R6 long reversal done", int'(dir[0]), 1);
      quiesce(9000);
      latch_check(0, "R7 pos ch0 long timing");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule